// File: doc/BRIEF.md
# Number Match Draw Controller

This block sits between a host-side byte FIFO bridge and an experiment board that produces random numbers on request. At power-up it holds the USB bridge in reset and keeps the bus transceivers disabled for a fixed settling period. It then releases both together and reports two identification bytes to the host: first the installed board type, then the board's own number. Both are written through the FIFO write strobe.

The block then waits for the host to send a target byte and keeps its low three bits as the target. It fires a one-cycle draw pulse at the board and waits for the board to flag a valid result. If the result differs from the target, it draws again. It keeps drawing, with no limit, until the result equals the target. On a match it raises the buzzer and writes a confirmation byte to the host. The buzzer stays on until the host sends a new target, and that target starts a fresh sequence.

Top module: `draw_match_ctrl`

## Requirements
- R1: After reset, `bridge_rst_no` and `xcvr_en_o` are both 0 for exactly INIT_CYCLES (default 16) rising clock edges. They then become 1 on the same edge and stay 1. While they are 0 there is no draw pulse, no read strobe and no write strobe.
- R2: Once initialization is done, the block writes two bytes to the host: first `board_type_i`, then `board_num_i`. A write begins only when `host_tx_ready_i` was high at the edge that starts it.
- R3: A host read begins only when `host_rx_ready_i` was high at the edge that starts it. `host_rd_o` is held for STROBE_CYCLES (default 2, at least 2) cycles. The target is bits [2:0] of `host_data_i` in the last cycle of the strobe.
- R4: Each draw is one clock cycle of `draw_o`. The first draw begins on the edge that ends the target read.
- R5: With the result-valid flag high, a mismatching `result_i` gives a cycle with `draw_o` low and then a new draw pulse. This repeats for as long as results mismatch.
- R6: `buzzer_o` rises on the edge that samples a valid, matching result. It then stays high until a new target read completes, or until reset.
- R7: After a match, the confirmation byte CONFIRM_CODE (default 8'hA5) is written to the host once. The write starts only while `host_tx_ready_i` is high. No further draws occur.
- R8: Reading a new target clears the buzzer and starts a new draw sequence that compares against the new target.
- R9: `result_valid_i` has no effect unless the block is waiting for a result. Read and write strobes are never active together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_rx_ready_i | input | 1 | Host FIFO holds a byte for the block |
| host_tx_ready_i | input | 1 | Host FIFO can accept a byte |
| host_data_i | input | 8 | Byte from the host FIFO |
| host_rd_o | output | 1 | Read strobe to the host FIFO |
| host_wr_o | output | 1 | Write strobe to the host FIFO |
| host_data_o | output | 8 | Byte to the host FIFO |
| board_type_i | input | 8 | Installed board type |
| board_num_i | input | 8 | Board number from the experiment board |
| draw_o | output | 1 | One-cycle draw request to the board |
| result_valid_i | input | 1 | Board result is valid this cycle |
| result_i | input | 3 | Number drawn by the board |
| buzzer_o | output | 1 | Match indicator |
| bridge_rst_no | output | 1 | USB bridge reset, 0 holds the bridge in reset |
| xcvr_en_o | output | 1 | Bus transceiver enable |

## Verification
The assertions assume a host that keeps its data byte steady while a read strobe is active. They also assume a board that raises result-valid for one cycle, and only after a draw request. The bench drives every input at the falling edge. Its board model waits for each draw pulse and answers two cycles later with a single valid cycle. The bench also pulses result-valid once while no draw is pending, to show that such a pulse is ignored. The host model presents a byte and holds it until the read strobe drops. It lowers transmit-ready on purpose to show that writes are held back.

// File: rtl/dm_pkg.sv
package dm_pkg;
  typedef enum logic [3:0] {
    ST_INIT, ST_SEND_TYPE, ST_SEND_NUM, ST_WAIT_TGT,
    ST_DRAW, ST_WAIT_RES, ST_GAP, ST_CONFIRM, ST_MATCHED
  } draw_st_e;

  typedef enum logic [1:0] {PT_IDLE, PT_WR, PT_RD} port_st_e;
endpackage

// File: rtl/dm_init_gate.sv
module dm_init_gate #(
  parameter int INIT_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic done_o
);
  localparam int CW = $clog2(INIT_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(INIT_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == LIMIT);
endmodule

// File: rtl/dm_host_port.sv
module dm_host_port
  import dm_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int STROBE_CYCLES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_req_i,
  input  logic [DATA_W-1:0] wr_byte_i,
  input  logic              rd_req_i,
  input  logic              rx_ready_i,
  input  logic              tx_ready_i,
  input  logic [DATA_W-1:0] rx_byte_i,
  output logic              rd_o,
  output logic              wr_o,
  output logic [DATA_W-1:0] tx_byte_o,
  output logic [DATA_W-1:0] rd_byte_o,
  output logic              done_o
);
  localparam int SW = $clog2(STROBE_CYCLES + 1);
  localparam logic [SW-1:0] LAST = SW'(STROBE_CYCLES - 1);

  port_st_e          st_q;
  logic [SW-1:0]     cnt_q;
  logic [DATA_W-1:0] tx_q;
  logic              last;

  assign last = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= PT_IDLE;
      cnt_q <= '0;
      tx_q  <= '0;
    end else begin
      case (st_q)
        PT_IDLE: begin
          cnt_q <= '0;
          // writes win: the control FSM never requests both at once
          if (wr_req_i && tx_ready_i) begin
            st_q <= PT_WR;
            tx_q <= wr_byte_i;
          end else if (rd_req_i && rx_ready_i) begin
            st_q <= PT_RD;
          end
        end
        default: begin
          if (last) st_q  <= PT_IDLE;
          else      cnt_q <= cnt_q + 1'b1;
        end
      endcase
    end
  end

  assign wr_o      = (st_q == PT_WR);
  assign rd_o      = (st_q == PT_RD);
  assign tx_byte_o = tx_q;
  assign rd_byte_o = rx_byte_i;
  assign done_o    = (st_q != PT_IDLE) && last;
endmodule

// File: rtl/dm_draw_fsm.sv
module dm_draw_fsm
  import dm_pkg::*;
#(
  parameter int          DATA_W       = 8,
  parameter int          NUM_W        = 3,
  parameter logic [7:0]  CONFIRM_CODE = 8'hA5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_done_i,
  input  logic              port_done_i,
  input  logic [DATA_W-1:0] rd_byte_i,
  input  logic [DATA_W-1:0] board_type_i,
  input  logic [DATA_W-1:0] board_num_i,
  input  logic              result_valid_i,
  input  logic [NUM_W-1:0]  result_i,
  output logic              wr_req_o,
  output logic [DATA_W-1:0] wr_byte_o,
  output logic              rd_req_o,
  output logic              draw_o,
  output logic              buzzer_o
);
  draw_st_e         st_q;
  logic [NUM_W-1:0] target_q;
  logic             buzz_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_INIT;
      target_q <= '0;
      buzz_q   <= 1'b0;
    end else begin
      case (st_q)
        ST_INIT:      if (init_done_i) st_q <= ST_SEND_TYPE;
        ST_SEND_TYPE: if (port_done_i) st_q <= ST_SEND_NUM;
        ST_SEND_NUM:  if (port_done_i) st_q <= ST_WAIT_TGT;
        ST_WAIT_TGT, ST_MATCHED: begin
          if (port_done_i) begin
            target_q <= rd_byte_i[NUM_W-1:0];
            buzz_q   <= 1'b0;
            st_q     <= ST_DRAW;
          end
        end
        ST_DRAW:      st_q <= ST_WAIT_RES;
        ST_WAIT_RES: begin
          if (result_valid_i) begin
            if (result_i == target_q) begin
              buzz_q <= 1'b1;
              st_q   <= ST_CONFIRM;
            end else begin
              st_q   <= ST_GAP;
            end
          end
        end
        ST_GAP:       st_q <= ST_DRAW;
        ST_CONFIRM:   if (port_done_i) st_q <= ST_MATCHED;
        default:      st_q <= ST_INIT;
      endcase
    end
  end

  always_comb begin
    wr_req_o  = 1'b0;
    wr_byte_o = '0;
    case (st_q)
      ST_SEND_TYPE: begin wr_req_o = 1'b1; wr_byte_o = board_type_i; end
      ST_SEND_NUM:  begin wr_req_o = 1'b1; wr_byte_o = board_num_i;  end
      ST_CONFIRM:   begin wr_req_o = 1'b1; wr_byte_o = DATA_W'(CONFIRM_CODE); end
      default: ;
    endcase
  end

  assign rd_req_o = (st_q == ST_WAIT_TGT) || (st_q == ST_MATCHED);
  assign draw_o   = (st_q == ST_DRAW);
  assign buzzer_o = buzz_q;
endmodule

// File: rtl/draw_match_ctrl.sv
module draw_match_ctrl #(
  parameter int         DATA_W        = 8,
  parameter int         NUM_W         = 3,
  parameter int         INIT_CYCLES   = 16,
  parameter int         STROBE_CYCLES = 2,
  parameter logic [7:0] CONFIRM_CODE  = 8'hA5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_rx_ready_i,
  input  logic              host_tx_ready_i,
  input  logic [DATA_W-1:0] host_data_i,
  output logic              host_rd_o,
  output logic              host_wr_o,
  output logic [DATA_W-1:0] host_data_o,
  input  logic [DATA_W-1:0] board_type_i,
  input  logic [DATA_W-1:0] board_num_i,
  output logic              draw_o,
  input  logic              result_valid_i,
  input  logic [NUM_W-1:0]  result_i,
  output logic              buzzer_o,
  output logic              bridge_rst_no,
  output logic              xcvr_en_o
);
  logic              init_done;
  logic              wr_req, rd_req, port_done;
  logic [DATA_W-1:0] wr_byte, rd_byte;

  dm_init_gate #(.INIT_CYCLES(INIT_CYCLES)) u_init (
    .clk_i(clk_i), .rst_ni(rst_ni), .done_o(init_done)
  );

  dm_host_port #(.DATA_W(DATA_W), .STROBE_CYCLES(STROBE_CYCLES)) u_port (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_req_i(wr_req), .wr_byte_i(wr_byte), .rd_req_i(rd_req),
    .rx_ready_i(host_rx_ready_i), .tx_ready_i(host_tx_ready_i),
    .rx_byte_i(host_data_i), .rd_o(host_rd_o), .wr_o(host_wr_o),
    .tx_byte_o(host_data_o), .rd_byte_o(rd_byte), .done_o(port_done)
  );

  dm_draw_fsm #(.DATA_W(DATA_W), .NUM_W(NUM_W), .CONFIRM_CODE(CONFIRM_CODE)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .init_done_i(init_done),
    .port_done_i(port_done), .rd_byte_i(rd_byte),
    .board_type_i(board_type_i), .board_num_i(board_num_i),
    .result_valid_i(result_valid_i), .result_i(result_i),
    .wr_req_o(wr_req), .wr_byte_o(wr_byte), .rd_req_o(rd_req),
    .draw_o(draw_o), .buzzer_o(buzzer_o)
  );

  // bridge leaves reset and transceivers open on the same edge
  assign bridge_rst_no = init_done;
  assign xcvr_en_o     = init_done;
endmodule

// File: rtl/draw_match_ctrl_chk.sv
module draw_match_ctrl_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              host_rx_ready_i,
  input logic              host_tx_ready_i,
  input logic              host_rd_o,
  input logic              host_wr_o,
  input logic [DATA_W-1:0] host_data_o,
  input logic              draw_o,
  input logic              result_valid_i,
  input logic              buzzer_o,
  input logic              bridge_rst_no,
  input logic              xcvr_en_o
);
  AST_GATE_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bridge_rst_no == xcvr_en_o);                                         // R1
  AST_GATE_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bridge_rst_no |=> bridge_rst_no);                                    // R1
  AST_QUIET_PRE_INIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bridge_rst_no |-> !draw_o && !host_rd_o && !host_wr_o);             // R1
  AST_WR_NEEDS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(host_wr_o) |-> $past(host_tx_ready_i));                        // R2
  AST_WR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(host_wr_o) |=> host_wr_o && $stable(host_data_o));             // R7
  AST_RD_NEEDS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(host_rd_o) |-> $past(host_rx_ready_i));                        // R3
  AST_RD_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(host_rd_o) |=> host_rd_o);                                     // R3
  AST_DRAW_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    draw_o |=> !draw_o);                                                 // R4
  AST_BUZZ_FROM_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(buzzer_o) |-> $past(result_valid_i));                          // R6
  AST_BUZZ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buzzer_o && !host_rd_o |=> buzzer_o);                                // R6
  AST_NO_RD_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(host_rd_o && host_wr_o));                                          // R9
endmodule

bind draw_match_ctrl draw_match_ctrl_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_draw_match_ctrl.sv
module tb_draw_match_ctrl;
  localparam int CLK_P = 10;
  localparam int INIT  = 16;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       rx_rdy = 1'b0, tx_rdy = 1'b0;
  logic [7:0] h_din = '0, h_dout;
  logic       rd, wr, draw, buzz, brst_n, xen;
  logic [7:0] btype = 8'h3C, bnum = 8'h17;
  logic       rvalid = 1'b0;
  logic [2:0] res = '0;

  int n_tests = 0, n_fail = 0;
  int wcount = 0, rd_count = 0, rd_short = 0, rd_run = 0, draw_count = 0;
  logic [7:0] wlog [0:15];
  logic wr_prev = 1'b0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  draw_match_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .host_rx_ready_i(rx_rdy), .host_tx_ready_i(tx_rdy),
    .host_data_i(h_din), .host_rd_o(rd), .host_wr_o(wr), .host_data_o(h_dout),
    .board_type_i(btype), .board_num_i(bnum), .draw_o(draw),
    .result_valid_i(rvalid), .result_i(res), .buzzer_o(buzz),
    .bridge_rst_no(brst_n), .xcvr_en_o(xen)
  );

  always @(posedge clk) begin
    if (wr && !wr_prev && wcount < 16) begin
      wlog[wcount] = h_dout;
      wcount++;
    end
    wr_prev = wr;
    if (rd) begin
      if (rd_run == 0) rd_count++;
      rd_run++;
    end else begin
      if (rd_run != 0 && rd_run < 2) rd_short++;
      rd_run = 0;
    end
    if (draw) draw_count++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_until_draw();
    for (int i = 0; i < 60 && !draw; i++) @(negedge clk);
  endtask

  task automatic board_reply(input logic [2:0] v, input bit match, input int draws_exp);
    wait_until_draw();
    chk(draw == 1'b1, "R4 draw pulse seen", draw, 1);
    @(negedge clk);
    chk(draw == 1'b0, "R4 draw one cycle", draw, 0);
    rvalid = 1'b1; res = v;
    @(negedge clk);
    rvalid = 1'b0;
    chk(draw == 1'b0, "R5 gap after result", draw, 0);
    chk(buzz == match, "R6 buzzer after compare", buzz, match);
    chk(draw_count == draws_exp, "R5 draw count", draw_count, draws_exp);
    if (!match) begin
      @(negedge clk);
      chk(draw == 1'b1, "R5 redraw after mismatch", draw, 1);
    end
  endtask

  task automatic t_reset();
    chk({brst_n, xen, draw, buzz, rd, wr} == 6'b0, "R1 reset outputs",
        {brst_n, xen, draw, buzz, rd, wr}, 0);
  endtask

  task automatic t_init();
    bit early = 0;
    rst_n = 1'b1;
    for (int k = 1; k < INIT; k++) begin
      @(negedge clk);
      if (brst_n || xen) early = 1;
    end
    chk(!early, "R1 held during init", early, 0);
    @(negedge clk);
    chk(brst_n && xen, "R1 released together", {brst_n, xen}, 2'b11);
    repeat (6) @(negedge clk);
    chk(wcount == 0, "R2 no write without tx ready", wcount, 0);
  endtask

  task automatic t_ident();
    tx_rdy = 1'b1;
    for (int i = 0; i < 30 && wcount < 2; i++) @(negedge clk);
    chk(wcount == 2 && wlog[0] == btype, "R2 board type first", wlog[0], btype);
    chk(wlog[1] == bnum, "R2 board number second", wlog[1], bnum);
    tx_rdy = 1'b0;
  endtask

  task automatic t_target_wait();
    rvalid = 1'b1; res = 3'd3;
    @(negedge clk);
    rvalid = 1'b0;
    repeat (10) @(negedge clk);
    chk(rd_count == 0, "R3 no read without rx ready", rd_count, 0);
    chk(draw_count == 0 && !buzz, "R9 stray result ignored", {draw_count[3:0], buzz}, 0);
    h_din = 8'hF3; rx_rdy = 1'b1;
    for (int i = 0; i < 20 && rd_count < 1; i++) @(negedge clk);
    while (rd) @(negedge clk);
    rx_rdy = 1'b0;
    chk(rd_count == 1 && rd_short == 0, "R3 read strobe width", rd_short, 0);
    chk(draw == 1'b1, "R4 draw right after read", draw, 1);
  endtask

  task automatic t_draw_loop();
    board_reply(3'd5, 1'b0, 1);
    board_reply(3'd1, 1'b0, 2);
    board_reply(3'd3, 1'b1, 3);
    repeat (10) @(negedge clk);
    chk(wcount == 2, "R7 confirm waits for tx ready", wcount, 2);
    chk(draw_count == 3, "R7 no draws after match", draw_count, 3);
    tx_rdy = 1'b1;
    for (int i = 0; i < 20 && wcount < 3; i++) @(negedge clk);
    chk(wcount == 3 && wlog[2] == 8'hA5, "R7 confirm byte", wlog[2], 8'hA5);
    repeat (20) @(negedge clk);
    chk(buzz == 1'b1, "R6 buzzer held", buzz, 1);
    chk(wcount == 3 && draw_count == 3, "R7 single confirm", wcount, 3);
  endtask

  task automatic t_retarget();
    h_din = 8'h0E; rx_rdy = 1'b1;
    for (int i = 0; i < 20 && rd_count < 2; i++) @(negedge clk);
    while (rd) @(negedge clk);
    rx_rdy = 1'b0;
    chk(buzz == 1'b0, "R8 buzzer cleared by new target", buzz, 0);
    board_reply(3'd3, 1'b0, 4);
    board_reply(3'd6, 1'b1, 5);
    for (int i = 0; i < 20 && wcount < 4; i++) @(negedge clk);
    chk(wcount == 4 && wlog[3] == 8'hA5, "R8 confirm after new target", wlog[3], 8'hA5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_init();
    t_ident();
    t_target_wait();
    t_draw_loop();
    t_retarget();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule